// File: doc/BRIEF.md
# Serial Latched-Driver Load Controller

This controller sits on the host side of a cascadable serial-in, latched-output display driver chain. It takes one parallel word per transfer over a valid/ready handshake. It then shifts the word out on a serial data pin under a generated shift clock and pulses a strobe so the driver latches the shifted word. It can also hold the driver's blanking input high for the whole transfer.

Every timing interval is a parameter given in nanoseconds, together with the system clock period. These intervals are data setup and hold around the rising shift-clock edge, the shift-clock high time, the minimum shift-clock period, the gap from the last rising edge to the strobe, and the strobe width. Each one is converted to whole system-clock cycles, rounded up. With the defaults (10 ns system clock) the controller holds the shift clock low for 5 cycles and high for 5 cycles per bit. It waits 5 more low cycles after the last bit and then holds the strobe high for 5 cycles.

Back-pressure: a word is taken on a rising system-clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the strobe pulse ends. A source may hold `in_valid` and change `in_data` while `in_ready` is low; nothing is captured until `in_ready` returns.

Top module: `serial_load_ctrl`

## Requirements
- R1: Bits leave most-significant first. One bit is sent per shift-clock rising edge. After WIDTH rising edges and the strobe, a downstream shift-and-latch chain holds exactly the accepted word, with its MSB in the stage nearest the chain's serial output.
- R2: `ser_data` settles at least LO cycles before each rising edge of `ser_clk`, where LO = max(ceil(setup), ceil(min period) - HI, 1) (5 with defaults).
- R3: `ser_data` does not change while `ser_clk` is high. The high phase lasts HI = max(ceil(clock high), ceil(hold), 1) cycles (5 with defaults), which covers the hold time.
- R4: `ser_clk` is high for exactly HI cycles per bit, and successive rising edges are LO+HI cycles apart (10 with defaults, i.e. 10 MHz).
- R5: `latch_stb` rises max(ceil(clock-to-strobe) - HI, 1) + HI cycles after the last `ser_clk` rising edge (10 with defaults), and `ser_clk` stays low while the strobe is high.
- R6: `latch_stb` stays high for exactly max(ceil(strobe width), 1) cycles (5 with defaults) per transfer.
- R7: `in_ready` goes low on the accepting edge and stays low until the strobe ends. Changes to `in_data` and `blank_mode` while it is low have no effect on the transfer.
- R8: `load_done` is high for exactly one cycle, the cycle right after the strobe falls. `in_ready` is high again in that same cycle.
- R9: When `blank_mode` is 1 at the accepting edge, `blank_out` is high from the cycle after acceptance through the end of the strobe, and low again together with `load_done`. When `blank_mode` is 0, `blank_out` stays low.
- R10: During and after reset, `ser_clk`, `latch_stb`, `blank_out` and `load_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Controller can take a word |
| in_data | input | WIDTH | Word to load, MSB sent first |
| blank_mode | input | 1 | Blank the driver for the whole transfer |
| ser_clk | output | 1 | Shift clock to the driver chain |
| ser_data | output | 1 | Serial data to the driver chain |
| latch_stb | output | 1 | Strobe that copies the shift register into the latches |
| blank_out | output | 1 | Blanking level to the driver |
| load_done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Counting from the accepting edge as cycle m = 0, every output has a closed-form expected value. `ser_clk` is high when m < WIDTH*(LO+HI) and m mod (LO+HI) >= LO. `ser_data` carries bit WIDTH-1-floor(m/(LO+HI)). The strobe covers the STB cycles starting at WIDTH*(LO+HI)+GAPLO, and `load_done` and `in_ready` come back at the following cycle. The bench counts m itself and samples every output on the falling clock edge after each rising edge, so each registered result is compared in the exact cycle it is due. A behavioural model of the driver chain is clocked from the sampled pins, and the word it latches is compared with the offered word after each back-to-back transfer.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_STB
  } slc_state_e;

  // Whole system-clock cycles covering a time span, rounded up.
  function automatic int unsigned span_cycles(int unsigned span_ns, int unsigned period_ns);
    return (span_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub_floor(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/slc_phase_timer.sv
module slc_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

  // A fresh load of zero means a one-cycle phase; a count never wraps.
  assert_timer_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(remain) != '0 && !$past(load)) |-> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/slc_bit_shifter.sv
module slc_bit_shifter #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  output logic             msb
);

  logic [WIDTH-1:0] word_q;

  generate
    if (WIDTH > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (load) begin
          word_q <= load_word;
        end else if (shift) begin
          word_q <= {word_q[WIDTH-2:0], 1'b0};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (load) begin
          word_q <= load_word;
        end
      end
    end
  endgenerate

  assign msb = word_q[WIDTH-1];

  // R1: a loaded word presents its top bit on the next cycle.
  assert_load_presents_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(load_word[WIDTH-1])));

endmodule

// File: rtl/serial_load_ctrl.sv
module serial_load_ctrl
  import slc_pkg::*;
#(
  parameter int WIDTH               = 20,
  parameter int SYS_PERIOD_NS       = 10,
  parameter int SETUP_NS            = 25,
  parameter int HOLD_NS             = 25,
  parameter int CLK_HIGH_NS         = 50,
  parameter int MIN_SCLK_PERIOD_NS  = 100,
  parameter int CLK_TO_STB_NS       = 100,
  parameter int STB_WIDTH_NS        = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             blank_mode,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             latch_stb,
  output logic             blank_out,
  output logic             load_done
);

  localparam int unsigned SU_C   = span_cycles(SETUP_NS, SYS_PERIOD_NS);
  localparam int unsigned HD_C   = span_cycles(HOLD_NS, SYS_PERIOD_NS);
  localparam int unsigned CH_C   = span_cycles(CLK_HIGH_NS, SYS_PERIOD_NS);
  localparam int unsigned PER_C  = span_cycles(MIN_SCLK_PERIOD_NS, SYS_PERIOD_NS);
  localparam int unsigned GAP_C  = span_cycles(CLK_TO_STB_NS, SYS_PERIOD_NS);
  localparam int unsigned SW_C   = span_cycles(STB_WIDTH_NS, SYS_PERIOD_NS);

  localparam int unsigned HI_C    = umax(umax(CH_C, HD_C), 1);
  localparam int unsigned LO_C    = umax(umax(SU_C, usub_floor(PER_C, HI_C)), 1);
  localparam int unsigned GAPLO_C = umax(usub_floor(GAP_C, HI_C), 1);
  localparam int unsigned STB_C   = umax(SW_C, 1);
  localparam int unsigned MAXPH_C = umax(umax(HI_C, LO_C), umax(GAPLO_C, STB_C));
  localparam int CW = $clog2(MAXPH_C + 1);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  localparam logic [CW-1:0] LO_M1    = CW'(LO_C - 1);
  localparam logic [CW-1:0] HI_M1    = CW'(HI_C - 1);
  localparam logic [CW-1:0] GAPLO_M1 = CW'(GAPLO_C - 1);
  localparam logic [CW-1:0] STB_M1   = CW'(STB_C - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  slc_state_e    state;
  logic [BW-1:0] bit_idx;
  logic          ready_q, sclk_q, stb_q, blank_q, done_q;
  logic          accept, last_bit, phase_end;
  logic          tmr_load, sh_shift;
  logic [CW-1:0] tmr_val;

  assign accept   = in_valid && ready_q && (state == ST_IDLE);
  assign last_bit = (bit_idx == LAST_BIT);

  slc_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_end)
  );

  slc_bit_shifter #(.WIDTH(WIDTH)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (in_data),
    .shift     (sh_shift),
    .msb       (ser_data)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = LO_M1;
      end
      ST_LOW: if (phase_end) begin
        tmr_load = 1'b1;
        tmr_val  = HI_M1;
      end
      ST_HIGH: if (phase_end) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          tmr_val = GAPLO_M1;
        end else begin
          tmr_val  = LO_M1;
          sh_shift = 1'b1;
        end
      end
      ST_GAP: if (phase_end) begin
        tmr_load = 1'b1;
        tmr_val  = STB_M1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      ready_q <= 1'b1;
      sclk_q  <= 1'b0;
      stb_q   <= 1'b0;
      blank_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_LOW;
          bit_idx <= '0;
          ready_q <= 1'b0;
          blank_q <= blank_mode;
        end
        ST_LOW: if (phase_end) begin
          state  <= ST_HIGH;
          sclk_q <= 1'b1;
        end
        ST_HIGH: if (phase_end) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            state <= ST_GAP;
          end else begin
            state   <= ST_LOW;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_GAP: if (phase_end) begin
          state <= ST_STB;
          stb_q <= 1'b1;
        end
        ST_STB: if (phase_end) begin
          state   <= ST_IDLE;
          stb_q   <= 1'b0;
          blank_q <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = ready_q;
  assign ser_clk   = sclk_q;
  assign latch_stb = stb_q;
  assign blank_out = blank_q;
  assign load_done = done_q;

  assert_data_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  assert_no_clock_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> !ser_clk);

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> ($past(latch_stb) && !latch_stb && in_ready));

  assert_blank_follows_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (blank_out == $past(blank_mode)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_clk && !latch_stb && !blank_out));

endmodule

// File: tb/serial_load_ctrl_tb.sv
module serial_load_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 20;
  localparam int LO    = 5;
  localparam int HI    = 5;
  localparam int P     = LO + HI;
  localparam int GAPLO = 5;
  localparam int STB   = 5;
  localparam int SEND  = W * P;
  localparam int ENDC  = SEND + GAPLO + STB;
  localparam int NPAT  = W + 4;
  localparam int NLOAD = 2 * NPAT;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, blank_mode;
  logic [W-1:0] in_data;
  logic         ser_clk, ser_data, latch_stb, blank_out, load_done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_load_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .blank_mode(blank_mode), .ser_clk(ser_clk),
    .ser_data(ser_data), .latch_stb(latch_stb), .blank_out(blank_out),
    .load_done(load_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp_v, $time);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int k);
    logic [W-1:0] v;
    v = '0;
    if (k == 0)      v = '0;
    else if (k == 1) v = '1;
    else if (k == 2 || k == 3) begin
      for (int b = 0; b < W; b++) v[b] = b[0];
      if (k == 3) v = ~v;
    end else v = W'(1) << (k - 4);
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL R8 watchdog actual=no_finish expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] chain, latched, word;
    logic         prev_sclk, mode;
    int           last_rise, stb_len, stb_rise;
    chain = '0; latched = '0; prev_sclk = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; blank_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10 reset ready", 32'(in_ready), 1);
    chk("R10 reset sclk/stb/blank/done", {ser_clk, latch_stb, blank_out, load_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 post-reset ready", 32'(in_ready), 1);
    chk("R10 post-reset quiet", {ser_clk, latch_stb, blank_out, load_done}, 0);

    in_data = pattern(0); blank_mode = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j < NLOAD; j++) begin
      word = pattern(j % NPAT);
      mode = (j >= NPAT);
      last_rise = -1; stb_len = 0; stb_rise = -1;
      for (int m = 0; m <= ENDC; m++) begin
        @(negedge clk);
        if (m == 0) begin
          if (j + 1 < NLOAD) begin
            in_data    = pattern((j + 1) % NPAT);
            blank_mode = ((j + 1) >= NPAT);
          end else begin
            in_valid   = 1'b0;
            in_data    = ~word;
            blank_mode = ~mode;
          end
        end
        // driver chain model
        if (ser_clk && !prev_sclk) begin
          chain = {chain[W-2:0], ser_data};
          last_rise = m;
        end
        if (latch_stb) begin
          latched = chain;
          if (stb_rise < 0) stb_rise = m;
          stb_len++;
        end
        prev_sclk = ser_clk;

        chk("R4 ser_clk", 32'(ser_clk), 32'((m < SEND) && ((m % P) >= LO)));
        if (m < SEND) begin
          if ((m % P) < LO) chk("R2 ser_data setup", 32'(ser_data), 32'(word[W-1-(m/P)]));
          else              chk("R3 ser_data hold", 32'(ser_data), 32'(word[W-1-(m/P)]));
        end
        chk("R5 latch_stb", 32'(latch_stb), 32'((m >= SEND + GAPLO) && (m < ENDC)));
        chk("R7 in_ready", 32'(in_ready), 32'(m == ENDC));
        chk("R8 load_done", 32'(load_done), 32'(m == ENDC));
        chk("R9 blank_out", 32'(blank_out), 32'(mode && (m < ENDC)));
      end
      chk("R1 latched word", 32'(latched), 32'(word));
      chk("R7 capture ignores later in_data", 32'(latched), 32'(word));
      chk("R6 strobe width", 32'(stb_len), STB);
      chk("R5 last rise to strobe", 32'(stb_rise - last_rise), GAPLO + HI);
    end
    @(negedge clk);
    chk("R8 done single pulse", 32'(load_done), 0);
    chk("R10 idle after last load", {in_ready, ser_clk, latch_stb, blank_out}, 32'b1000);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule